// File: doc/BRIEF.md
# Pipelined 32x32 Multiplier with Selectable Product Half

This block multiplies two 32-bit operands and returns one 32-bit half of the 64-bit product. A 2-bit operation code picks the half and how each operand's signedness is treated. The four choices are the low word, the high word with both operands signed, the high word with a signed first operand and an unsigned second operand, and the high word with both operands unsigned. It is meant to sit in the execute stage of an integer core as the multiply functional unit.

One datapath serves all four choices. Each operand is widened by one bit. The new top bit copies the operand's sign when that operand is treated as signed and is zero otherwise. A single signed 33x33 multiply then covers every case, and a final selector returns bits 31:0 or 63:32. An operation is accepted in any cycle in which `in_valid` is high. Its result appears with `out_valid` two clock edges later, so a new operation can be issued every cycle.

Top module: `mulhw_top`

## Requirements
- R1: While `rst` is high on a rising edge, the next cycle shows `out_valid` = 0 and `result` = 0.
- R2: `out_valid` is high exactly in the cycles that follow the second rising edge after an edge where `in_valid` was high. Back-to-back operations are all accepted and delivered in issue order.
- R3: With `op` = 2'b00, `result` is bits 31:0 of the product, and the signedness of the operands does not matter. For example, 0xFFFFFFFF x 0xFFFFFFFF gives 0x00000001 and 0xAAAAAAAB x 0x0002FE7D gives 0x0000FF7F.
- R4: With `op` = 2'b01, `result` is bits 63:32 of the signed-by-signed product, and the operation is commutative. For example, 0xFF000000 squared gives 0x00010000, 0xFFFFFFFF x 1 gives 0xFFFFFFFF, and 0xAAAAAAAB x 0x0002FE7D gives 0xFFFF0081 in either operand order.
- R5: With `op` = 2'b10, `result` is bits 63:32 of the product of signed `opa` and unsigned `opb`, and the operation is not commutative. For example, 0x80000000 x 0xFFFF8000 gives 0x80004000, 0x0002FE7D x 0xAAAAAAAB gives 0x0001FEFE, and 0xAAAAAAAB x 0x0002FE7D gives 0xFFFF0081.
- R6: With `op` = 2'b11, `result` is bits 63:32 of the unsigned-by-unsigned product. For example, 0xFFFFFFFF squared gives 0xFFFFFFFE and 0x80000000 x 0xFFFF8000 gives 0x7FFFC000.
- R7: In a cycle where `out_valid` is low, `result` keeps the value it had in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation strobe; the operands and `op` are captured on this edge |
| op | input | 2 | 00 low word, 01 high signed x signed, 10 high signed x unsigned, 11 high unsigned x unsigned |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| out_valid | output | 1 | Result strobe, two edges after acceptance |
| result | output | 32 | Selected product half |

## Verification
Every result is due on the second rising edge after the edge that accepted its operation. The bench drives and samples on the falling edge. It keeps a two-deep history of what it issued, and at each falling edge it compares `out_valid` and `result` against the entry issued two falling edges earlier. Cycles without a valid result are checked against the last delivered value, which exercises the hold rule. The same two-stage timing is mirrored by the checker's own shift registers.

// File: rtl/mulhw_pkg.sv
package mulhw_pkg;

    localparam int XLEN   = 32;
    localparam int EXT_W  = XLEN + 1;
    localparam int PROD_W = 2 * EXT_W;

    // Operation encoding; the product half and the signedness of each
    // operand both follow from this code.
    typedef enum logic [1:0] {
        MOP_LO  = 2'b00,
        MOP_HSS = 2'b01,
        MOP_HSU = 2'b10,
        MOP_HUU = 2'b11
    } mop_e;

    // Stage-one payload: widened operands and the half selector.
    typedef struct packed {
        logic                    vld;
        logic                    take_hi;
        logic [EXT_W-1:0]        xa;
        logic [EXT_W-1:0]        xb;
    } stg1_t;

    function automatic logic first_is_signed(input mop_e m);
        return (m == MOP_HSS) || (m == MOP_HSU);
    endfunction

    function automatic logic second_is_signed(input mop_e m);
        return (m == MOP_HSS);
    endfunction

    function automatic logic wants_high(input mop_e m);
        return (m != MOP_LO);
    endfunction

endpackage

// File: rtl/mulhw_opext.sv
module mulhw_opext #(
    parameter int W = 32
) (
    input  logic [W-1:0] val,
    input  logic         sgn,
    output logic [W:0]   ext
);
    // Top bit copies the sign only when the operand is treated as signed.
    always_comb begin
        ext = {sgn & val[W-1], val};
    end
endmodule

// File: rtl/mulhw_halfsel.sv
module mulhw_halfsel #(
    parameter int W = 32
) (
    input  logic [2*W+1:0] prod,
    input  logic           hi,
    output logic [W-1:0]   half
);
    localparam int LO_MSB = W - 1;
    localparam int HI_LSB = W;
    localparam int HI_MSB = 2 * W - 1;

    always_comb begin
        if (hi) half = prod[HI_MSB:HI_LSB];
        else    half = prod[LO_MSB:0];
    end
endmodule

// File: rtl/mulhw_top.sv
module mulhw_top
    import mulhw_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [1:0]      op,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    output logic            out_valid,
    output logic [XLEN-1:0] result
);
    localparam int NOPS = 2;

    mop_e             mode;
    logic [XLEN-1:0]  raw  [NOPS];
    logic             sgn  [NOPS];
    logic [EXT_W-1:0] wide [NOPS];

    stg1_t                     s1_q;
    logic signed [PROD_W-1:0]  prod;
    logic [XLEN-1:0]           half;

    always_comb begin
        mode   = mop_e'(op);
        raw[0] = opa;
        raw[1] = opb;
        sgn[0] = first_is_signed(mode);
        sgn[1] = second_is_signed(mode);
    end

    for (genvar g = 0; g < NOPS; g++) begin : g_ext
        mulhw_opext #(.W(XLEN)) u_ext (
            .val (raw[g]),
            .sgn (sgn[g]),
            .ext (wide[g])
        );
    end

    // Stage 1: capture widened operands.
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
        end else begin
            s1_q.vld <= in_valid;
            if (in_valid) begin
                s1_q.take_hi <= wants_high(mode);
                s1_q.xa      <= wide[0];
                s1_q.xb      <= wide[1];
            end
        end
    end

    // One signed multiply covers all signedness combinations.
    always_comb begin
        prod = PROD_W'($signed(s1_q.xa)) * PROD_W'($signed(s1_q.xb));
    end

    mulhw_halfsel #(.W(XLEN)) u_sel (
        .prod (prod),
        .hi   (s1_q.take_hi),
        .half (half)
    );

    // Stage 2: register the selected half; hold it between operations.
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= s1_q.vld;
            if (s1_q.vld) result <= half;
        end
    end

endmodule

// File: rtl/mulhw_chk.sv
module mulhw_chk
    import mulhw_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic [1:0]      op,
    input logic [XLEN-1:0] opa,
    input logic [XLEN-1:0] opb,
    input logic            out_valid,
    input logic [XLEN-1:0] result
);
    logic            v1, v2;
    logic [1:0]      o1, o2;
    logic [XLEN-1:0] a1, a2, b1, b2;

    always_ff @(posedge clk) begin
        if (rst) begin
            v1 <= 1'b0; v2 <= 1'b0;
            o1 <= '0; o2 <= '0;
            a1 <= '0; a2 <= '0; b1 <= '0; b2 <= '0;
        end else begin
            v1 <= in_valid; v2 <= v1;
            o1 <= op;  o2 <= o1;
            a1 <= opa; a2 <= a1;
            b1 <= opb; b2 <= b1;
        end
    end

    function automatic logic [2*XLEN-1:0] full_prod(
        input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
        input logic sa, input logic sb);
        logic [2*XLEN-1:0] ea, eb;
        ea = {{XLEN{sa & a[XLEN-1]}}, a};
        eb = {{XLEN{sb & b[XLEN-1]}}, b};
        return ea * eb;
    endfunction

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && result == '0));
    // R2
    valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid == v2);
    // R3
    low_word_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && o2 == 2'b00) |-> result == full_prod(a2, b2, 1'b0, 1'b0)[XLEN-1:0]);
    // R4
    high_ss_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && o2 == 2'b01) |-> result == full_prod(a2, b2, 1'b1, 1'b1)[2*XLEN-1:XLEN]);
    // R5
    high_su_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && o2 == 2'b10) |-> result == full_prod(a2, b2, 1'b1, 1'b0)[2*XLEN-1:XLEN]);
    // R6
    high_uu_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && o2 == 2'b11) |-> result == full_prod(a2, b2, 1'b0, 1'b0)[2*XLEN-1:XLEN]);
    // R7
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(result));

endmodule

bind mulhw_top mulhw_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op        (op),
    .opa       (opa),
    .opb       (opb),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/sim_mulhw_top.sv
`timescale 1ns/1ps
module sim_mulhw_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic        out_valid;
    logic [31:0] result;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic        hv1 = 0, hv2 = 0;
    logic [1:0]  ho1 = 0, ho2 = 0;
    logic [31:0] ha1 = 0, ha2 = 0, hb1 = 0, hb2 = 0;
    logic [31:0] last_res = 0;

    always #2.5 clk = ~clk;

    mulhw_top u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
        .opa(opa), .opb(opb), .out_valid(out_valid), .result(result)
    );

    function automatic logic [31:0] expect_val(input logic [1:0] o,
                                               input logic [31:0] a,
                                               input logic [31:0] b);
        logic sa, sb;
        logic [63:0] ea, eb, p;
        sa = (o == 2'b01) || (o == 2'b10);
        sb = (o == 2'b01);
        ea = sa ? {{32{a[31]}}, a} : {32'd0, a};
        eb = sb ? {{32{b[31]}}, b} : {32'd0, b};
        p  = ea * eb;
        return (o == 2'b00) ? p[31:0] : p[63:32];
    endfunction

    function automatic string op_tag(input logic [1:0] o);
        case (o)
            2'b00:   return "R3";
            2'b01:   return "R4";
            2'b10:   return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick(input logic v, input logic [1:0] o,
                        input logic [31:0] a, input logic [31:0] b);
        logic [31:0] e;
        @(negedge clk);
        // R2: valid due two edges after the issuing edge
        check(out_valid == hv2, "R2", {31'd0, out_valid}, {31'd0, hv2});
        if (hv2) begin
            e = expect_val(ho2, ha2, hb2);
            check(result == e, op_tag(ho2), result, e);
            last_res = e;
        end else begin
            // R7: idle cycle keeps previous result
            check(result == last_res, "R7", result, last_res);
        end
        hv2 = hv1; ho2 = ho1; ha2 = ha1; hb2 = hb1;
        hv1 = v;   ho1 = o;   ha1 = a;   hb1 = b;
        in_valid = v; op = o; opa = a; opb = b;
    endtask

    function automatic logic [31:0] pick_operand();
        case ($urandom % 8)
            0: return 32'h0000_0000;
            1: return 32'h0000_0001;
            2: return 32'hFFFF_FFFF;
            3: return 32'h8000_0000;
            4: return 32'h7FFF_FFFF;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        int seed_ret;
        seed_ret = $urandom(32'd20240611);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0, "R1", {31'd0, out_valid}, 32'd0);
        check(result == 32'd0, "R1", result, 32'd0);

        // Directed corners, back to back (R2 throughput)
        tick(1, 2'b00, 32'hFFFFFFFF, 32'hFFFFFFFF); // R3
        tick(1, 2'b00, 32'hAAAAAAAB, 32'h0002FE7D); // R3
        tick(1, 2'b01, 32'hFFFFFFFF, 32'hFFFFFFFF); // R4
        tick(1, 2'b10, 32'hFFFFFFFF, 32'hFFFFFFFF); // R5
        tick(1, 2'b11, 32'hFFFFFFFF, 32'hFFFFFFFF); // R6
        tick(1, 2'b01, 32'hFF000000, 32'hFF000000); // R4
        tick(1, 2'b10, 32'hFF000000, 32'hFF000000); // R5
        tick(1, 2'b11, 32'hFF000000, 32'hFF000000); // R6
        tick(1, 2'b10, 32'h80000000, 32'hFFFF8000); // R5
        tick(1, 2'b11, 32'h80000000, 32'hFFFF8000); // R6
        tick(1, 2'b10, 32'h0002FE7D, 32'hAAAAAAAB); // R5 order matters
        tick(1, 2'b10, 32'hAAAAAAAB, 32'h0002FE7D); // R5
        tick(1, 2'b01, 32'hAAAAAAAB, 32'h0002FE7D); // R4 commutative
        tick(1, 2'b01, 32'h0002FE7D, 32'hAAAAAAAB); // R4
        tick(1, 2'b01, 32'hFFFFFFFF, 32'h00000001); // R4 sign extension
        tick(0, 2'b11, 32'h12345678, 32'h9ABCDEF0); // R7 ignored while idle
        tick(0, 2'b00, 32'hFFFFFFFF, 32'hFFFFFFFF);
        tick(0, 2'b00, 32'h0, 32'h0);

        // Random traffic with gaps
        for (int i = 0; i < 3000; i++) begin
            tick(($urandom % 4) != 0, 2'($urandom), pick_operand(), pick_operand());
        end
        for (int i = 0; i < 4; i++) tick(0, 2'b00, 32'h0, 32'h0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                #(200000 * 5);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule